// File: doc/BRIEF.md
# Limit-Check Sticky Interrupt Status

This block watches seven measured channels: four supply voltages and three temperature zones. It compares each reading against a programmable pair of limits. A reading that falls outside its window sets a sticky bit in an 8-bit status byte. The bit stays set until a host read takes place while the reading is back inside its window. The readings and limits come from elsewhere in the chip. This block only does the comparison, holds the status, and computes the interrupt.

The top bit of the byte is not an event. It is a live summary that tells the host whether either of two companion status registers has any bit set. The host can therefore poll this one byte and read the other two registers only when that summary bit is 1. An interrupt line goes high while any bit of the byte is set.

The host reads the byte on `status_o`. Driving `rd_stb_i` high for one cycle marks that read and starts the conditional clear. Writes are accepted on the same interface and are discarded.

Top module: `lim_stat_top`

## Requirements
- R1: Status bit positions: bit 0 is the 2.5 V supply, bit 1 the core supply, bit 2 the 3.3 V supply, bit 3 the 5 V supply, bit 4 temperature zone 1, bit 5 zone 2, bit 6 zone 3. In the flat input buses, channel k occupies bits [8k+7:8k].
- R2: A channel violates its limits when its reading is less than or equal to its low limit, or strictly greater than its high limit. A reading equal to the high limit is not a violation.
- R3: Once a status bit is set, it stays set on every cycle without a read strobe, even after the reading returns inside its window.
- R4: On the clock edge that ends a read strobe cycle, each of bits 0 to 6 clears if its channel is not in violation during that cycle.
- R5: If a channel is in violation during the read strobe cycle, its bit is set, or stays set, after that edge. Setting wins over clearing.
- R6: On each clock edge, bit 7 takes the value 1 when any bit of either companion status input is 1, and 0 otherwise. Read strobes do not affect it.
- R7: While synchronous active-high reset is applied, the status byte is 00h and the interrupt line is 0 after each clock edge.
- R8: Write strobes and write data do not change the status byte.
- R9: Voltage channels 0 to 3 compare readings and limits as 8-bit unsigned values. Temperature channels 4 to 6 compare them as 8-bit two's-complement values.
- R10: On each clock edge, the interrupt line takes the OR of all eight status bits as they stood before that edge.
- R11: During the read strobe cycle, `status_o` shows the value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reading_i | input | 56 | Seven 8-bit readings, channel k at [8k+7:8k] |
| lo_lim_i | input | 56 | Seven 8-bit low limits, same layout |
| hi_lim_i | input | 56 | Seven 8-bit high limits, same layout |
| aux_a_i | input | 8 | Contents of the first companion status register |
| aux_b_i | input | 8 | Contents of the second companion status register |
| rd_stb_i | input | 1 | Host read of the status byte, one cycle |
| wr_stb_i | input | 1 | Host write strobe (ignored) |
| wr_data_i | input | 8 | Host write data (ignored) |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt, registered OR of the status byte |

## Verification
A faulty sticky flop appears on `status_o` one edge after the stimulus that should have set or held it. Examples are a bit that drops without a read, or one that clears during a read while its reading is still outside its window. A wrong comparator sign or boundary is also visible one edge after the reading reaches its limit value. An error in the interrupt register or in the summary bit shows one further edge later on `irq_o`. Each cycle is compared against a model, so any of these faults is reported within two cycles of the input that exposes it.

// File: rtl/lim_stat_pkg.sv
package lim_stat_pkg;
    localparam int DW      = 8;
    localparam int N_VOLT  = 4;
    localparam int N_TEMP  = 3;
    localparam int N_CH    = N_VOLT + N_TEMP;
    localparam int SUM_BIT = N_CH;
    localparam int STAT_W  = N_CH + 1;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_kind_e;

    typedef struct packed {
        logic [DW-1:0] value;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } chan_t;

    function automatic cmp_kind_e kind_of(input int ch);
        return (ch >= N_VOLT) ? CMP_SIGNED : CMP_UNSIGNED;
    endfunction

    function automatic logic out_of_window(input chan_t c, input cmp_kind_e k);
        logic below, above;
        if (k == CMP_SIGNED) begin
            below = $signed(c.value) <= $signed(c.lo);
            above = $signed(c.value) >  $signed(c.hi);
        end else begin
            below = c.value <= c.lo;
            above = c.value >  c.hi;
        end
        return below | above;
    endfunction
endpackage

// File: rtl/lim_cmp.sv
module lim_cmp
    import lim_stat_pkg::*;
#(
    parameter cmp_kind_e KIND = CMP_UNSIGNED
) (
    input  chan_t chan_i,
    output logic  viol_o
);
    always_comb viol_o = out_of_window(chan_i, KIND);
endmodule

// File: rtl/lim_sticky.sv
module lim_sticky #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] viol_i,
    input  logic         rd_stb_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= viol_i | (flag_q & {N{~rd_stb_i}});
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/lim_stat_top.sv
module lim_stat_top
    import lim_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CH*DW-1:0]   reading_i,
    input  logic [N_CH*DW-1:0]   lo_lim_i,
    input  logic [N_CH*DW-1:0]   hi_lim_i,
    input  logic [DW-1:0]        aux_a_i,
    input  logic [DW-1:0]        aux_b_i,
    input  logic                 rd_stb_i,
    input  logic                 wr_stb_i,
    input  logic [DW-1:0]        wr_data_i,
    output logic [STAT_W-1:0]    status_o,
    output logic                 irq_o
);
    logic [N_CH-1:0] viol;
    logic [N_CH-1:0] flags;
    logic            sum_q;
    logic            irq_q;
    logic            wr_unused;

    assign wr_unused = wr_stb_i ^ (^wr_data_i);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        chan_t c;
        assign c.value = reading_i[g*DW +: DW];
        assign c.lo    = lo_lim_i[g*DW +: DW];
        assign c.hi    = hi_lim_i[g*DW +: DW];
        lim_cmp #(.KIND(kind_of(g))) u_cmp (
            .chan_i (c),
            .viol_o (viol[g])
        );
    end

    lim_sticky #(.N(N_CH)) u_sticky (
        .clk      (clk),
        .rst      (rst),
        .viol_i   (viol),
        .rd_stb_i (rd_stb_i),
        .flag_o   (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            sum_q <= (|aux_a_i) | (|aux_b_i);
            irq_q <= |status_o;
        end
    end

    assign status_o = {sum_q, flags};
    assign irq_o    = irq_q;
endmodule

// File: rtl/lim_stat_chk.sv
module lim_stat_chk
    import lim_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DW-1:0]     aux_a_i,
    input logic [DW-1:0]     aux_b_i,
    input logic              rd_stb_i,
    input logic [N_CH-1:0]   viol,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o
);
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_i |=> ((status_o[N_CH-1:0] & $past(status_o[N_CH-1:0])) == $past(status_o[N_CH-1:0]))); // R3

    AST_READ_CLEARS_IDLE: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |=> ((status_o[N_CH-1:0] & ~$past(viol)) == '0)); // R4

    AST_ACTIVE_WINS: assert property (@(posedge clk) disable iff (rst)
        rd_stb_i |=> ((status_o[N_CH-1:0] & $past(viol)) == $past(viol))); // R5

    AST_SUMMARY_LIVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_o[SUM_BIT] == ((|$past(aux_a_i)) | (|$past(aux_b_i))))); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (status_o == '0 && !irq_o)); // R7

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> (irq_o == (|$past(status_o)))); // R10
endmodule

bind lim_stat_top lim_stat_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .aux_a_i  (aux_a_i),
    .aux_b_i  (aux_b_i),
    .rd_stb_i (rd_stb_i),
    .viol     (viol),
    .status_o (status_o),
    .irq_o    (irq_o)
);

// File: tb/lim_stat_top_tb.sv
module lim_stat_top_tb;
    import lim_stat_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [STAT_W-1:0] st;
        logic              irq;
        string             tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N_CH*DW-1:0]   reading_i, lo_lim_i, hi_lim_i;
    logic [DW-1:0]        aux_a_i = '0, aux_b_i = '0;
    logic                 rd_stb_i = 1'b0, wr_stb_i = 1'b0;
    logic [DW-1:0]        wr_data_i = '0;
    logic [STAT_W-1:0]    status_o;
    logic                 irq_o;

    logic [DW-1:0] rdg [N_CH];
    logic [DW-1:0] lo  [N_CH];
    logic [DW-1:0] hi  [N_CH];

    exp_t              sb_q[$];
    logic [STAT_W-1:0] m_st = '0;
    int                n_cmp = 0;
    int                n_bad = 0;
    bit                done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < N_CH; k++) begin
            reading_i[k*DW +: DW] = rdg[k];
            lo_lim_i[k*DW +: DW]  = lo[k];
            hi_lim_i[k*DW +: DW]  = hi[k];
        end
    end

    lim_stat_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .reading_i (reading_i),
        .lo_lim_i  (lo_lim_i),
        .hi_lim_i  (hi_lim_i),
        .aux_a_i   (aux_a_i),
        .aux_b_i   (aux_b_i),
        .rd_stb_i  (rd_stb_i),
        .wr_stb_i  (wr_stb_i),
        .wr_data_i (wr_data_i),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_viol(input int k);
        if (k >= N_VOLT)
            return ($signed(rdg[k]) <= $signed(lo[k])) || ($signed(rdg[k]) > $signed(hi[k]));
        return (rdg[k] <= lo[k]) || (rdg[k] > hi[k]);
    endfunction

    // Inputs are already set for this cycle; compute the outputs after the next edge.
    task automatic push_exp(input string tag);
        exp_t e;
        logic [N_CH-1:0] v;
        for (int k = 0; k < N_CH; k++) v[k] = model_viol(k);
        e.tag = tag;
        if (rst) begin
            e.st  = '0;
            e.irq = 1'b0;
        end else begin
            e.irq = |m_st;
            e.st  = {(|aux_a_i) | (|aux_b_i), v | (m_st[N_CH-1:0] & {N_CH{~rd_stb_i}})};
        end
        m_st = e.st;
        sb_q.push_back(e);
    endtask

    task automatic step(input string tag);
        push_exp(tag);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {1'b0, status_o}, {1'b0, e.st});
                check("R10 irq", {8'h0, irq_o}, {8'h0, e.irq});
            end
        end
    end

    initial begin
        for (int k = 0; k < N_CH; k++) begin
            if (k < N_VOLT) begin
                rdg[k] = 8'd100; lo[k] = 8'd50; hi[k] = 8'd200;
            end else begin
                rdg[k] = 8'd25; lo[k] = 8'hF6; hi[k] = 8'd80;
            end
        end
        @(negedge clk);
        rst = 1'b1;
        step("R7 reset");
        step("R7 reset");
        rst = 1'b0;
        step("R2 all inside");
        rdg[0] = 8'd50;                      // low limit inclusive
        step("R2 low equal bit0 R1");
        rdg[0] = 8'd100;
        step("R3 bit0 held");
        rdg[1] = 8'd200;                     // equal high: no violation
        step("R2 high equal");
        rdg[1] = 8'd201;
        step("R2 high above bit1 R1");
        rdg[1] = 8'd100;
        step("R3 both held");
        rd_stb_i = 1'b1;
        check("R11 snapshot", {1'b0, status_o}, 9'h003);
        step("R4 read clears");
        rd_stb_i = 1'b0;
        rdg[2] = 8'd0;
        step("R1 bit2");
        rd_stb_i = 1'b1;
        step("R5 active survives read");
        rd_stb_i = 1'b0;
        rdg[2] = 8'd100;
        step("R3 bit2 held");
        rd_stb_i = 1'b1;
        step("R4 bit2 cleared");
        rd_stb_i = 1'b0;
        rdg[3] = 8'hFF;                      // unsigned 255 > 200
        rdg[4] = 8'hFF;                      // signed -1 inside window
        step("R9 unsigned vs signed");
        rdg[3] = 8'd100;
        rdg[4] = 8'h80;                      // -128 below -10
        step("R9 zone1 bit4");
        rdg[4] = 8'd25;
        rdg[5] = 8'hF6;                      // equal signed low
        step("R2 signed low equal bit5");
        rdg[5] = 8'd25;
        rdg[6] = 8'd81;
        step("R1 bit6");
        rdg[6] = 8'd25;
        wr_stb_i = 1'b1; wr_data_i = 8'h00;
        step("R8 write zero ignored");
        rd_stb_i = 1'b1; wr_stb_i = 1'b0;
        step("R4 all cleared");
        rd_stb_i = 1'b0;
        wr_stb_i = 1'b1; wr_data_i = 8'hFF;
        step("R8 write ones ignored");
        wr_stb_i = 1'b0;
        aux_a_i = 8'h04;
        step("R6 summary from a");
        aux_a_i = 8'h00; aux_b_i = 8'h80; rd_stb_i = 1'b1;
        step("R6 summary from b");
        rd_stb_i = 1'b0; aux_b_i = 8'h00;
        step("R6 summary drops");
        step("R10 idle");
        step("R10 idle");
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule